// File: doc/BRIEF.md
# AU Pointer Interpreter

This block reads the two pointer bytes of an administrative unit once per frame and keeps track of where the VC-3 or VC-4 payload starts. The two bytes form one 16-bit word. Bits 15:12 hold the new-data field, bits 11:10 hold the size bits, and bits 9:0 hold the offset. The offset range is 0 to 782 in both formats, so one interpreter serves an STM-0 VC-3 and an STM-1 VC-4 without a mode pin.

The interpreter follows normal pointers, increments, decrements and new-data events. It raises an AIS alarm or a loss-of-pointer alarm when the pointer stream calls for one. It counts positive and negative justifications in saturating counters, and it drives an AIS-insert request to the downstream payload path. Configuration pins select whether the size bits are checked, and whether downstream AIS is forced on or suppressed. A one-cycle clear strobe empties both counters.

The pointer bytes arrive on a valid/ready stream. `ptr_ready` is low during reset and high in every cycle after it, so the block never applies back-pressure. Every cycle with `ptr_valid` and `ptr_ready` both high counts as one frame. A source that holds `ptr_valid` high for several cycles delivers that many frames.

Top module: `au_ptr_interp`

## Requirements
- R1: In reset and in the first cycle after it: `ptr_ready` is 0 during reset and 1 afterwards; `alarm_lop` is 1; `alarm_ais`, `ndf_event`, `ptr_value` and both counters are 0.
- R2: A word is a "normal valid pointer" when all of the following hold: bits 15:12 are within one bit of 0110, the size bits pass R6, and the offset is at most 782. Three consecutive normal valid pointers with the same offset that differs from the current one make that offset current. They also enter the normal state and clear both alarms. In any other case `ptr_value` changes only through R3, R4 or R5.
- R3: An increment is recognised in the normal state when both of the following hold: at least 3 of the odd offset bits (9,7,5,3,1) are inverted relative to the current value, and fewer than 3 of the even bits are inverted. An increment raises `ptr_value` by one, wrapping from 782 to 0, and adds one to `pos_just_cnt`. An increment pattern is ignored outside the normal state.
- R4: A decrement is recognised in the normal state when both of the following hold: at least 3 of the even offset bits (8,6,4,2,0) are inverted, and fewer than 3 odd bits are inverted. A decrement lowers `ptr_value` by one, wrapping from 0 to 782, and adds one to `neg_just_cnt`.
- R5: A word whose bits 15:12 are within one bit of 1001, with valid size bits and an offset of at most 782, is taken at once in the normal or AIS state. It enters the normal state and pulses `ndf_event` for one cycle. In the loss-of-pointer state such a word is treated as invalid.
- R6: With `cfg_ss_check` = 1, the size bits must equal 10; otherwise the word is invalid. With `cfg_ss_check` = 0 they are ignored.
- R7: Three consecutive all-ones words set `alarm_ais`.
- R8: Eight consecutive frames that are invalid pointers or unaccepted new offsets set `alarm_lop`. An all-ones word, an accepted pointer or a repeat of the current offset restarts the count.
- R9: Each justification counter is 11 bits wide and stays at 2047 once it reaches that value. `cnt_clear` zeroes both counters and wins over an increment in the same cycle.
- R10: `ais_insert` is 1 when `cfg_ais_force` is 1, or when `cfg_ais_dis` is 0 and either alarm is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_valid | input | 1 | Pointer bytes present this cycle |
| ptr_ready | output | 1 | Block accepts a frame (high out of reset) |
| ptr_h1 | input | 8 | First pointer byte (word bits 15:8) |
| ptr_h2 | input | 8 | Second pointer byte (word bits 7:0) |
| cfg_ss_check | input | 1 | 1: size bits must be 10 |
| cfg_ais_force | input | 1 | Force downstream AIS |
| cfg_ais_dis | input | 1 | Suppress alarm-driven AIS |
| cnt_clear | input | 1 | Clear both justification counters |
| ptr_value | output | 10 | Current payload offset |
| alarm_ais | output | 1 | AU-AIS state |
| alarm_lop | output | 1 | Loss-of-pointer state |
| ndf_event | output | 1 | One-cycle pulse on an accepted new-data pointer |
| pos_just_cnt | output | 11 | Positive justification count |
| neg_just_cnt | output | 11 | Negative justification count |
| ais_insert | output | 1 | Downstream AIS request |

## Verification
The offset, both alarms, `ndf_event` and both counters are registered on the edge that accepts a frame, so each frame's result can be read in the next cycle. `ais_insert` follows the configuration pins within the same cycle, and the alarm state one edge after the frame. The bench drives each frame on a falling edge and reads the outputs on the following falling edge, one full register stage later. Sequences that need several frames, such as three-frame acceptance or the eighth invalid frame, are checked after every frame, so the bench confirms that nothing happens early.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_AIS  = 2'd1,
    ST_LOP  = 2'd2
  } ptr_state_e;
endpackage

// File: rtl/ptr_decode.sv
// Classifies one received pointer word against the current offset.
module ptr_decode #(
  parameter int          PTR_W      = 10,
  parameter int          MAX_OFFSET = 782,
  parameter logic [1:0]  SS_EXPECT  = 2'b10
) (
  input  logic [15:0]      word,
  input  logic [PTR_W-1:0] cur,
  input  logic             ss_check,
  output logic             all_ones,
  output logic             ndf_enable,
  output logic             ndf_normal,
  output logic             ss_ok,
  output logic             in_range,
  output logic             inc_vote,
  output logic             dec_vote
);
  localparam int HALF = PTR_W / 2;
  localparam logic [3:0] NDF_ON  = 4'b1001;
  localparam logic [3:0] NDF_OFF = 4'b0110;

  logic [PTR_W-1:0] diff;
  logic [HALF-1:0]  odd_flip;
  logic [HALF-1:0]  even_flip;

  assign diff = word[PTR_W-1:0] ^ cur;

  for (genvar k = 0; k < HALF; k++) begin : g_split
    assign odd_flip[k]  = diff[2*k+1];
    assign even_flip[k] = diff[2*k];
  end

  always_comb begin
    all_ones   = &word;
    ndf_enable = $countones(word[15:12] ^ NDF_ON)  <= 1;
    ndf_normal = $countones(word[15:12] ^ NDF_OFF) <= 1;
    ss_ok      = !ss_check || (word[11:10] == SS_EXPECT);
    in_range   = int'(word[PTR_W-1:0]) <= MAX_OFFSET;
    inc_vote   = ($countones(odd_flip) > HALF/2)  && ($countones(even_flip) <= HALF/2);
    dec_vote   = ($countones(even_flip) > HALF/2) && ($countones(odd_flip) <= HALF/2);
  end
endmodule

// File: rtl/ptr_state_fsm.sv
// Pointer state machine: offset tracking, alarms and justification pulses.
module ptr_state_fsm
  import ptr_pkg::*;
#(
  parameter int PTR_W         = 10,
  parameter int MAX_OFFSET    = 782,
  parameter int AIS_FRAMES    = 3,
  parameter int LOP_FRAMES    = 8,
  parameter int ACCEPT_FRAMES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [PTR_W-1:0] rx_value,
  input  logic             all_ones,
  input  logic             ndf_enable,
  input  logic             ndf_normal,
  input  logic             ss_ok,
  input  logic             in_range,
  input  logic             inc_vote,
  input  logic             dec_vote,
  output ptr_state_e       state,
  output logic [PTR_W-1:0] ptr_value,
  output logic             inc_pulse,
  output logic             dec_pulse,
  output logic             ndf_event
);
  localparam int AIS_W = $clog2(AIS_FRAMES + 1);
  localparam int LOP_W = $clog2(LOP_FRAMES + 1);
  localparam int ACC_W = $clog2(ACCEPT_FRAMES + 1);
  localparam logic [PTR_W-1:0] MAX_V = PTR_W'(MAX_OFFSET);

  ptr_state_e       state_q, state_n;
  logic [PTR_W-1:0] value_q, value_n;
  logic [PTR_W-1:0] cand_q, cand_n;
  logic [ACC_W-1:0] cand_cnt_q, cand_cnt_n;
  logic [AIS_W-1:0] ais_cnt_q, ais_cnt_n;
  logic [LOP_W-1:0] inv_cnt_q, inv_cnt_n;
  logic             ndf_q, ndf_n;
  logic             normal_ok, ndf_ok;

  assign normal_ok = ss_ok && ndf_normal;
  assign ndf_ok    = ss_ok && ndf_enable && in_range;

  always_comb begin
    state_n    = state_q;
    value_n    = value_q;
    cand_n     = cand_q;
    cand_cnt_n = cand_cnt_q;
    ais_cnt_n  = ais_cnt_q;
    inv_cnt_n  = inv_cnt_q;
    ndf_n      = 1'b0;
    inc_pulse  = 1'b0;
    dec_pulse  = 1'b0;
    if (fire) begin
      if (all_ones) begin
        inv_cnt_n  = '0;
        cand_cnt_n = '0;
        if (int'(ais_cnt_q) < AIS_FRAMES) ais_cnt_n = ais_cnt_q + 1'b1;
        if (int'(ais_cnt_q) + 1 >= AIS_FRAMES) state_n = ST_AIS;
      end else begin
        ais_cnt_n = '0;
        if (ndf_ok && state_q != ST_LOP) begin
          value_n    = rx_value;
          state_n    = ST_NORM;
          ndf_n      = 1'b1;
          inv_cnt_n  = '0;
          cand_cnt_n = '0;
        end else if (normal_ok && state_q == ST_NORM && rx_value == value_q) begin
          inv_cnt_n  = '0;
          cand_cnt_n = '0;
        end else if (normal_ok && state_q == ST_NORM && inc_vote) begin
          value_n    = (value_q == MAX_V) ? '0 : value_q + 1'b1;
          inc_pulse  = 1'b1;
          inv_cnt_n  = '0;
          cand_cnt_n = '0;
        end else if (normal_ok && state_q == ST_NORM && dec_vote) begin
          value_n    = (value_q == '0) ? MAX_V : value_q - 1'b1;
          dec_pulse  = 1'b1;
          inv_cnt_n  = '0;
          cand_cnt_n = '0;
        end else if (normal_ok && in_range) begin
          if (cand_cnt_q != '0 && rx_value == cand_q) begin
            cand_cnt_n = cand_cnt_q + 1'b1;
          end else begin
            cand_n     = rx_value;
            cand_cnt_n = ACC_W'(1);
          end
          if (int'(cand_cnt_n) >= ACCEPT_FRAMES) begin
            value_n    = rx_value;
            state_n    = ST_NORM;
            inv_cnt_n  = '0;
            cand_cnt_n = '0;
          end else begin
            if (int'(inv_cnt_q) < LOP_FRAMES) inv_cnt_n = inv_cnt_q + 1'b1;
            if (int'(inv_cnt_q) + 1 >= LOP_FRAMES) state_n = ST_LOP;
          end
        end else begin
          cand_cnt_n = '0;
          if (int'(inv_cnt_q) < LOP_FRAMES) inv_cnt_n = inv_cnt_q + 1'b1;
          if (int'(inv_cnt_q) + 1 >= LOP_FRAMES) state_n = ST_LOP;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_LOP;
      value_q    <= '0;
      cand_q     <= '0;
      cand_cnt_q <= '0;
      ais_cnt_q  <= '0;
      inv_cnt_q  <= '0;
      ndf_q      <= 1'b0;
    end else begin
      state_q    <= state_n;
      value_q    <= value_n;
      cand_q     <= cand_n;
      cand_cnt_q <= cand_cnt_n;
      ais_cnt_q  <= ais_cnt_n;
      inv_cnt_q  <= inv_cnt_n;
      ndf_q      <= ndf_n;
    end
  end

  assign state     = state_q;
  assign ptr_value = value_q;
  assign ndf_event = ndf_q;

  // R2
  value_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    value_q <= MAX_V);
  // R2
  value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(value_q));
  // R5
  ndf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ndf_q |-> $past(fire && !all_ones));
  // R7
  ais_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_AIS) |-> $past(fire && all_ones));
  // R8
  lop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_LOP) |-> $past(fire && !all_ones));
endmodule

// File: rtl/sat_counter.sv
// Saturating event counter with a synchronous clear that wins over counting.
module sat_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clr)                    cnt_q <= '0;
    else if (inc && cnt_q != TOP)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP && !clr) |=> cnt_q == TOP);
  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  // R9
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_q != TOP) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/au_ptr_interp.sv
// AU pointer interpreter top level.
module au_ptr_interp
  import ptr_pkg::*;
#(
  parameter int         PTR_W         = 10,
  parameter int         MAX_OFFSET    = 782,
  parameter int         CNT_W         = 11,
  parameter int         AIS_FRAMES    = 3,
  parameter int         LOP_FRAMES    = 8,
  parameter int         ACCEPT_FRAMES = 3,
  parameter logic [1:0] SS_EXPECT     = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_valid,
  output logic             ptr_ready,
  input  logic [7:0]       ptr_h1,
  input  logic [7:0]       ptr_h2,
  input  logic             cfg_ss_check,
  input  logic             cfg_ais_force,
  input  logic             cfg_ais_dis,
  input  logic             cnt_clear,
  output logic [PTR_W-1:0] ptr_value,
  output logic             alarm_ais,
  output logic             alarm_lop,
  output logic             ndf_event,
  output logic [CNT_W-1:0] pos_just_cnt,
  output logic [CNT_W-1:0] neg_just_cnt,
  output logic             ais_insert
);
  localparam int N_CNT = 2;

  logic        ready_q;
  logic        fire;
  logic [15:0] word;
  logic        all_ones, ndf_enable, ndf_normal, ss_ok, in_range, inc_vote, dec_vote;
  logic        inc_pulse, dec_pulse;
  ptr_state_e  state;
  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [N_CNT];

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign ptr_ready = ready_q;
  assign fire      = ptr_valid && ready_q;
  assign word      = {ptr_h1, ptr_h2};

  ptr_decode #(
    .PTR_W(PTR_W), .MAX_OFFSET(MAX_OFFSET), .SS_EXPECT(SS_EXPECT)
  ) i_decode (
    .word(word), .cur(ptr_value), .ss_check(cfg_ss_check),
    .all_ones(all_ones), .ndf_enable(ndf_enable), .ndf_normal(ndf_normal),
    .ss_ok(ss_ok), .in_range(in_range), .inc_vote(inc_vote), .dec_vote(dec_vote)
  );

  ptr_state_fsm #(
    .PTR_W(PTR_W), .MAX_OFFSET(MAX_OFFSET), .AIS_FRAMES(AIS_FRAMES),
    .LOP_FRAMES(LOP_FRAMES), .ACCEPT_FRAMES(ACCEPT_FRAMES)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n), .fire(fire), .rx_value(word[PTR_W-1:0]),
    .all_ones(all_ones), .ndf_enable(ndf_enable), .ndf_normal(ndf_normal),
    .ss_ok(ss_ok), .in_range(in_range), .inc_vote(inc_vote), .dec_vote(dec_vote),
    .state(state), .ptr_value(ptr_value), .inc_pulse(inc_pulse),
    .dec_pulse(dec_pulse), .ndf_event(ndf_event)
  );

  assign cnt_inc = {dec_pulse, inc_pulse};

  for (genvar j = 0; j < N_CNT; j++) begin : g_just
    sat_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clear), .inc(cnt_inc[j]), .cnt(cnt_val[j])
    );
  end

  assign pos_just_cnt = cnt_val[0];
  assign neg_just_cnt = cnt_val[1];
  assign alarm_ais    = (state == ST_AIS);
  assign alarm_lop    = (state == ST_LOP);
  assign ais_insert   = cfg_ais_force || (!cfg_ais_dis && (alarm_ais || alarm_lop));

  // R1
  ready_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ptr_ready);
  // R3
  inc_no_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_pulse && dec_pulse));
  // R10
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ais_force |-> ais_insert);
endmodule

// File: tb/test_au_ptr_interp.sv
module test_au_ptr_interp;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ptr_valid;
  logic        ptr_ready;
  logic [7:0]  ptr_h1, ptr_h2;
  logic        cfg_ss_check, cfg_ais_force, cfg_ais_dis, cnt_clear;
  logic [9:0]  ptr_value;
  logic        alarm_ais, alarm_lop, ndf_event, ais_insert;
  logic [10:0] pos_just_cnt, neg_just_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  au_ptr_interp i_au_ptr_interp (
    .clk(clk), .rst_n(rst_n), .ptr_valid(ptr_valid), .ptr_ready(ptr_ready),
    .ptr_h1(ptr_h1), .ptr_h2(ptr_h2), .cfg_ss_check(cfg_ss_check),
    .cfg_ais_force(cfg_ais_force), .cfg_ais_dis(cfg_ais_dis), .cnt_clear(cnt_clear),
    .ptr_value(ptr_value), .alarm_ais(alarm_ais), .alarm_lop(alarm_lop),
    .ndf_event(ndf_event), .pos_just_cnt(pos_just_cnt), .neg_just_cnt(neg_just_cnt),
    .ais_insert(ais_insert)
  );

  typedef struct packed {
    logic [15:0] w;
    logic [9:0]  v;
    logic        a;
    logic        l;
    logic        n;
    logic [10:0] pj;
    logic [10:0] nj;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    '{16'h6800 | 16'd100, 10'd0,   1'b0, 1'b1, 1'b0, 11'd0, 11'd0}, // R2 candidate 1
    '{16'h6800 | 16'd100, 10'd0,   1'b0, 1'b1, 1'b0, 11'd0, 11'd0}, // R2 candidate 2
    '{16'h6800 | 16'd100, 10'd100, 1'b0, 1'b0, 1'b0, 11'd0, 11'd0}, // R2 accepted
    '{16'h6800 | 16'd100, 10'd100, 1'b0, 1'b0, 1'b0, 11'd0, 11'd0}, // R2 steady
    '{16'h6800 | (16'd100 ^ 16'h2AA), 10'd101, 1'b0, 1'b0, 1'b0, 11'd1, 11'd0}, // R3 five odd flips
    '{16'h6800 | (16'd101 ^ 16'h155), 10'd100, 1'b0, 1'b0, 1'b0, 11'd1, 11'd1}, // R4 five even flips
    '{16'h6800 | (16'd100 ^ 16'h2A0), 10'd101, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R3 three flips
    '{16'h6800 | (16'd101 ^ 16'h280), 10'd101, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R3 two flips: no inc
    '{16'h6800 | 16'd101, 10'd101, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R2 steady
    '{16'h9800 | 16'd500, 10'd500, 1'b0, 1'b0, 1'b1, 11'd2, 11'd1}, // R5 exact enable
    '{16'h8800 | 16'd300, 10'd300, 1'b0, 1'b0, 1'b1, 11'd2, 11'd1}, // R5 one-bit error
    '{16'h0800 | 16'd300, 10'd300, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R8 bad flag, inv 1
    '{16'h6800 | 16'd800, 10'd300, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R8 out of range
    '{16'h6000 | 16'd300, 10'd300, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R6 size bits 00
    '{16'hFFFF,           10'd300, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R7 ones 1
    '{16'hFFFF,           10'd300, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R7 ones 2
    '{16'hFFFF,           10'd300, 1'b1, 1'b0, 1'b0, 11'd2, 11'd1}, // R7 ones 3
    '{16'h6800 | 16'd300, 10'd300, 1'b1, 1'b0, 1'b0, 11'd2, 11'd1}, // R7 stays
    '{16'h9800 | 16'd200, 10'd200, 1'b0, 1'b0, 1'b1, 11'd2, 11'd1}, // R5 exits AIS
    '{16'h6800 | 16'd1000, 10'd200, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R8 1
    '{16'h6800 | 16'd1000, 10'd200, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R8 2
    '{16'h6800 | 16'd1000, 10'd200, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R8 3
    '{16'h6800 | 16'd1000, 10'd200, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R8 4
    '{16'h6800 | 16'd1000, 10'd200, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R8 5
    '{16'h6800 | 16'd1000, 10'd200, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R8 6
    '{16'h6800 | 16'd1000, 10'd200, 1'b0, 1'b0, 1'b0, 11'd2, 11'd1}, // R8 7
    '{16'h6800 | 16'd1000, 10'd200, 1'b0, 1'b1, 1'b0, 11'd2, 11'd1}, // R8 8: LOP
    '{16'h6800 | (16'd200 ^ 16'h2AA), 10'd200, 1'b0, 1'b1, 1'b0, 11'd2, 11'd1}, // R3 no inc in LOP
    '{16'h9800 | 16'd50,  10'd200, 1'b0, 1'b1, 1'b0, 11'd2, 11'd1}  // R5 ignored in LOP
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one frame at a falling edge; results are read at the next falling edge.
  task automatic frame(input logic [15:0] w, input logic clr);
    ptr_valid = 1'b1;
    {ptr_h1, ptr_h2} = w;
    cnt_clear = clr;
    @(negedge clk);
    ptr_valid = 1'b0;
    cnt_clear = 1'b0;
  endtask

  task automatic pulse_clear();
    cnt_clear = 1'b1;
    @(negedge clk);
    cnt_clear = 1'b0;
  endtask

  function automatic logic [9:0] nxt(input logic [9:0] v);
    return (v == 10'd782) ? 10'd0 : v + 10'd1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] cur;
    rst_n = 1'b0; ptr_valid = 1'b0; ptr_h1 = '0; ptr_h2 = '0;
    cfg_ss_check = 1'b1; cfg_ais_force = 1'b0; cfg_ais_dis = 1'b0; cnt_clear = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(ptr_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", int'(ptr_ready), 1);
    chk("R1 lop", int'(alarm_lop), 1);
    chk("R1 ais", int'(alarm_ais), 0);
    chk("R1 ndf", int'(ndf_event), 0);
    chk("R1 value", int'(ptr_value), 0);
    chk("R1 pj", int'(pos_just_cnt), 0);
    chk("R1 nj", int'(neg_just_cnt), 0);
    chk("R10 insert on lop", int'(ais_insert), 1);

    for (int i = 0; i < NV; i++) begin
      frame(TBL[i].w, 1'b0);
      chk($sformatf("R2 value vec%0d", i), int'(ptr_value), int'(TBL[i].v));
      chk($sformatf("R7 ais vec%0d", i), int'(alarm_ais), int'(TBL[i].a));
      chk($sformatf("R8 lop vec%0d", i), int'(alarm_lop), int'(TBL[i].l));
      chk($sformatf("R5 ndf vec%0d", i), int'(ndf_event), int'(TBL[i].n));
      chk($sformatf("R3 pj vec%0d", i), int'(pos_just_cnt), int'(TBL[i].pj));
      chk($sformatf("R4 nj vec%0d", i), int'(neg_just_cnt), int'(TBL[i].nj));
    end
    @(negedge clk);
    chk("R5 ndf one cycle", int'(ndf_event), 0);

    // R10 force/disable while in LOP
    cfg_ais_dis = 1'b1; #1;
    chk("R10 disabled", int'(ais_insert), 0);
    cfg_ais_force = 1'b1; #1;
    chk("R10 force beats disable", int'(ais_insert), 1);
    cfg_ais_force = 1'b0; cfg_ais_dis = 1'b0; #1;
    chk("R10 lop insert", int'(ais_insert), 1);
    @(negedge clk);

    // R2 acceptance out of LOP at 782
    frame(16'h6800 | 16'd782, 1'b0);
    frame(16'h6800 | 16'd782, 1'b0);
    chk("R2 two frames not enough", int'(alarm_lop), 1);
    frame(16'h6800 | 16'd782, 1'b0);
    chk("R2 value 782", int'(ptr_value), 782);
    chk("R2 lop cleared", int'(alarm_lop), 0);
    chk("R10 no insert", int'(ais_insert), 0);
    cfg_ais_force = 1'b1; #1;
    chk("R10 forced", int'(ais_insert), 1);
    cfg_ais_force = 1'b0;
    @(negedge clk);

    // R3 / R4 wrap
    frame(16'h6800 | (16'd782 ^ 16'h2AA), 1'b0);
    chk("R3 wrap to 0", int'(ptr_value), 0);
    chk("R3 pj", int'(pos_just_cnt), 3);
    frame(16'h6800 | 16'h155, 1'b0);
    chk("R4 wrap to 782", int'(ptr_value), 782);
    chk("R4 nj", int'(neg_just_cnt), 2);

    // R9 clear, and clear beats a same-cycle increment
    pulse_clear();
    chk("R9 pj cleared", int'(pos_just_cnt), 0);
    chk("R9 nj cleared", int'(neg_just_cnt), 0);
    frame(16'h6800 | (16'd782 ^ 16'h2AA), 1'b1);
    chk("R9 clear wins value moves", int'(ptr_value), 0);
    chk("R9 clear wins", int'(pos_just_cnt), 0);
    frame(16'h6800 | 16'h2AA, 1'b0);
    chk("R9 counts after clear", int'(pos_just_cnt), 1);
    pulse_clear();

    // R6 size bits ignored, then checked
    cfg_ss_check = 1'b0;
    for (int k = 0; k < 3; k++) frame(16'h6000 | 16'd50, 1'b0);
    chk("R6 ignored accepts", int'(ptr_value), 50);
    cfg_ss_check = 1'b1;
    for (int k = 0; k < 3; k++) frame(16'h6000 | 16'd60, 1'b0);
    chk("R6 checked rejects", int'(ptr_value), 50);
    chk("R6 no lop yet", int'(alarm_lop), 0);

    // R9 saturation
    cur = 10'd50;
    for (int k = 0; k < 2050; k++) begin
      frame(16'h6800 | {6'd0, cur ^ 10'h2AA}, 1'b0);
      cur = nxt(cur);
    end
    chk("R9 saturated", int'(pos_just_cnt), 2047);
    chk("R3 value after run", int'(ptr_value), int'(cur));
    frame(16'h6800 | {6'd0, cur ^ 10'h2AA}, 1'b0);
    cur = nxt(cur);
    chk("R9 stays saturated", int'(pos_just_cnt), 2047);
    chk("R4 nj untouched", int'(neg_just_cnt), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule